// File: doc/BRIEF.md
# Serial PCM Audio Slot Receiver

This block pulls one channel out of a serial PCM audio stream. The stream has a bit clock, a frame clock and one data line. The block supports two-channel framing (the I2S and left-justified styles) and multi-slot TDM framing. All three lines are sampled by a faster system clock, and the chosen edge of the bit clock marks each bit period. The block counts frame-clock transitions, bit periods and slot indices, and it shifts in the bits of one selected slot. The stream is MSB first and two's complement.

The captured sample is held until the last bit period of the frame. It is then driven out as a 32-bit sign-extended word, together with a one-cycle valid pulse. Several receivers on the same bus therefore update in the same cycle, whatever slots they listen to. Every format setting is a static input that software may change at any time. A change drops the frame in progress, and the block waits for the next frame start before it captures again.

Top module: `pcm_slot_rx`

## Requirements
- R1: Samples are captured MSB first and sign-extended to 32 bits. Sample width code 00 selects 16 bits, code 01 selects 24 bits, and codes 10 and 11 select 32 bits.
- R2: Slot width code 00 gives 16 bit periods per slot, code 01 gives 24, and codes 10 and 11 give 32. Bits after the sample inside a slot have no effect on the output.
- R3: If the sample width exceeds the slot width, the first slot-width bits of the slot are taken and sign-extended. Neighbouring slots are never mixed in.
- R4: A frame-delay code n (0 to 3) places the first data bit of a frame n bit periods after the bit period in which the frame-clock edge is first seen. Trailing bits of the previous frame that fall into those n periods still belong to it.
- R5: A frame starts when the sampled frame clock changes to the level on the polarity input: 1 for left-justified, 0 for I2S. In two-channel mode (TDM input 0), each frame has exactly 2 slots. Slot 0 (left) is sent first, and the slot-count input is ignored.
- R6: In TDM mode (TDM input 1), slot-count code 00 gives 2 slots, code 01 gives 4, and codes 10 and 11 give 8. Slots arrive in ascending order after a one-bit-period frame pulse at the polarity level.
- R7: The 4-bit slot select names the slot index to capture, counted from 0 in order of arrival. An index at or above the slot count never produces a valid pulse.
- R8: When the rise input is 1, data is sampled at the rising bit-clock edge. When it is 0, data is sampled at the falling edge.
- R9: valid_o pulses for one cycle after the last bit of the last slot of a frame, not when the selected slot ends. sample_o holds its value between pulses.
- R10: A frame that is cut short by a new frame start produces no valid pulse.
- R11: Any configuration change drops the frame in progress. Capture resumes from the next frame start.
- R12: During reset, valid_o and sample_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame clock / frame pulse |
| sdata_i | input | 1 | Serial audio data |
| samp_w_i | input | 2 | Sample width code |
| slot_w_i | input | 2 | Slot width code |
| frm_dly_i | input | 2 | Frame delay in bit periods |
| fclk_pol_i | input | 1 | Frame-clock level that starts a frame / marks slot 0 |
| tdm_i | input | 1 | 1 = TDM framing, 0 = two-channel framing |
| slot_cnt_i | input | 2 | TDM slot count code |
| slot_sel_i | input | 4 | Index of the captured slot |
| rise_i | input | 1 | 1 = sample on rising bit-clock edge, 0 = falling |
| sample_o | output | 32 | Sign-extended captured sample |
| valid_o | output | 1 | One-cycle pulse at frame end |

## Verification
Each test drives a left-justified stream, a delayed I2S stream on the falling edge, and TDM streams with 8 and 4 slots. Every slot carries a distinct word, so capturing the wrong slot, bit order or width gives a different value. Padding bits are all ones, which exposes over-long shifting. For each valid pulse, the bench records the bit period in which it appears. This separates frame-end release from slot-end release and exposes a missed trailing bit under frame delays of 1 and 2. Separate streams cover the width clamp, an out-of-range slot index, a truncated frame and a mid-frame change of configuration. In each of these, the number of pulses is the discriminating observation.

// File: rtl/pcm_slot_rx_pkg.sv
package pcm_slot_rx_pkg;
  localparam int unsigned BIT_CNT_W  = 6;
  localparam int unsigned SLOT_IDX_W = 4;
  localparam int unsigned SAMPLE_W   = 32;

  typedef struct packed {
    logic [1:0] samp_code;
    logic [1:0] slot_code;
    logic [1:0] dly;
    logic       pol;
    logic       tdm;
    logic [1:0] cnt_code;
    logic [3:0] sel;
    logic       rise;
  } rx_cfg_t;

  function automatic logic [BIT_CNT_W-1:0] width_of(input logic [1:0] code);
    case (code)
      2'b00:   return BIT_CNT_W'(16);
      2'b01:   return BIT_CNT_W'(24);
      default: return BIT_CNT_W'(32);
    endcase
  endfunction

  function automatic logic [SLOT_IDX_W-1:0] slots_of(input logic tdm, input logic [1:0] code);
    if (!tdm) return SLOT_IDX_W'(2);
    case (code)
      2'b00:   return SLOT_IDX_W'(2);
      2'b01:   return SLOT_IDX_W'(4);
      default: return SLOT_IDX_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/pcm_slot_rx_sync.sv
module pcm_slot_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic bclk_i,
  input  logic fclk_i,
  input  logic dat_i,
  output logic stb_o,
  output logic fclk_o,
  output logic dat_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw, synced;
  logic            bclk_prev_q;

  assign raw = {bclk_i, fclk_i, dat_i};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], raw[i]};
    end
    assign synced[i] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_prev_q <= 1'b0;
    else         bclk_prev_q <= synced[2];
  end

  assign stb_o  = rise_i ? (synced[2] & ~bclk_prev_q) : (~synced[2] & bclk_prev_q);
  assign fclk_o = synced[1];
  assign dat_o  = synced[0];

  // R8
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o && $stable(rise_i) |=> !stb_o);
endmodule

// File: rtl/pcm_slot_rx_framer.sv
module pcm_slot_rx_framer
  import pcm_slot_rx_pkg::*;
#(
  parameter int unsigned CNT_W = BIT_CNT_W,
  parameter int unsigned IDX_W = SLOT_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rx_cfg_t          cfg_i,
  input  logic             stb_i,
  input  logic             fclk_i,
  input  logic             dat_i,
  output logic             tick_o,
  output logic             bit_o,
  output logic [CNT_W-1:0] bis_o,
  output logic [IDX_W-1:0] sidx_o,
  output logic             fresh_o,
  output logic             end_o
);
  rx_cfg_t          cfg_q;
  logic             fclk_prev_q, active_q, pend_q;
  logic [1:0]       wait_q;
  logic [CNT_W-1:0] bis_q;
  logic [IDX_W-1:0] sidx_q;

  logic [CNT_W-1:0] slot_bits, cur_bis;
  logic [IDX_W-1:0] n_slots, cur_sidx;
  logic             cfg_chg, start, pend_c, fresh, consume, slot_last, frame_last;
  logic [1:0]       wait_c;

  assign slot_bits  = width_of(cfg_i.slot_code);
  assign n_slots    = slots_of(cfg_i.tdm, cfg_i.cnt_code);
  assign cfg_chg    = cfg_i != cfg_q;
  assign start      = stb_i && (fclk_i == cfg_i.pol) && (fclk_prev_q != cfg_i.pol);
  // a new frame's bit 0 is deferred by the delay; old frame keeps consuming meanwhile
  assign pend_c     = start || pend_q;
  assign wait_c     = start ? cfg_i.dly : wait_q;
  assign fresh      = pend_c && (wait_c == 2'd0);
  assign cur_bis    = fresh ? '0 : bis_q;
  assign cur_sidx   = fresh ? '0 : sidx_q;
  assign consume    = stb_i && !cfg_chg && (fresh || active_q);
  assign slot_last  = cur_bis == slot_bits - 1'b1;
  assign frame_last = cur_sidx == n_slots - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      fclk_prev_q <= 1'b0;
      active_q    <= 1'b0;
      pend_q      <= 1'b0;
      wait_q      <= '0;
      bis_q       <= '0;
      sidx_q      <= '0;
    end else if (cfg_chg) begin
      cfg_q    <= cfg_i;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      wait_q   <= '0;
    end else if (stb_i) begin
      fclk_prev_q <= fclk_i;
      pend_q      <= pend_c && !fresh;
      wait_q      <= (pend_c && !fresh) ? wait_c - 2'd1 : 2'd0;
      if (consume) begin
        active_q <= 1'b1;
        if (slot_last) begin
          bis_q  <= '0;
          sidx_q <= cur_sidx + 1'b1;
          if (frame_last) active_q <= 1'b0;
        end else begin
          bis_q  <= cur_bis + 1'b1;
          sidx_q <= cur_sidx;
        end
      end
    end
  end

  assign tick_o  = consume;
  assign bit_o   = dat_i;
  assign bis_o   = cur_bis;
  assign sidx_o  = cur_sidx;
  assign fresh_o = stb_i && fresh && !cfg_chg;
  assign end_o   = consume && slot_last && frame_last;

  // R2
  bis_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !cfg_chg |-> bis_q < slot_bits);
  // R6
  sidx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !cfg_chg |-> sidx_q < n_slots);
  // R11
  cfg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |=> !active_q && !pend_q);
  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_o |=> active_q && sidx_q == '0);
endmodule

// File: rtl/pcm_slot_rx_capture.sv
module pcm_slot_rx_capture
  import pcm_slot_rx_pkg::*;
#(
  parameter int unsigned W     = SAMPLE_W,
  parameter int unsigned CNT_W = BIT_CNT_W,
  parameter int unsigned IDX_W = SLOT_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] samp_w_i,
  input  logic [CNT_W-1:0] slot_w_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic [IDX_W-1:0] n_slots_i,
  input  logic             tick_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] bis_i,
  input  logic [IDX_W-1:0] sidx_i,
  input  logic             fresh_i,
  input  logic             end_i,
  output logic [W-1:0]     sample_o,
  output logic             valid_o
);
  localparam int unsigned HALF = 16;
  localparam int unsigned TRIP = 24;

  logic [W-1:0]     sh_q, held_q, sample_q, sh_n, ext_n, val;
  logic             have_q, valid_q, take, done, emit;
  logic [CNT_W-1:0] eff_w;

  assign eff_w = (samp_w_i > slot_w_i) ? slot_w_i : samp_w_i;
  assign take  = tick_i && (sidx_i == sel_i) && (bis_i < eff_w);
  assign sh_n  = {sh_q[W-2:0], bit_i};
  assign done  = take && (bis_i == eff_w - 1'b1);

  always_comb begin
    case (eff_w)
      CNT_W'(HALF): ext_n = {{(W-HALF){sh_n[HALF-1]}}, sh_n[HALF-1:0]};
      CNT_W'(TRIP): ext_n = {{(W-TRIP){sh_n[TRIP-1]}}, sh_n[TRIP-1:0]};
      default:      ext_n = sh_n;
    endcase
  end

  // selected slot may itself be the last one: bypass the holding register
  assign val  = done ? ext_n : held_q;
  assign emit = end_i && (have_q || done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      held_q   <= '0;
      have_q   <= 1'b0;
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (take)    sh_q   <= sh_n;
      if (fresh_i) have_q <= 1'b0;
      if (done) begin
        held_q <= ext_n;
        have_q <= 1'b1;
      end
      valid_q <= emit;
      if (emit) sample_q <= val;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R9
  sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(sample_q));
  // R7
  oob_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && (sel_i >= n_slots_i) |=> !valid_q);
  // R3
  clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> bis_i < slot_w_i);
endmodule

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx
  import pcm_slot_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bclk_i,
  input  logic        fclk_i,
  input  logic        sdata_i,
  input  logic [1:0]  samp_w_i,
  input  logic [1:0]  slot_w_i,
  input  logic [1:0]  frm_dly_i,
  input  logic        fclk_pol_i,
  input  logic        tdm_i,
  input  logic [1:0]  slot_cnt_i,
  input  logic [3:0]  slot_sel_i,
  input  logic        rise_i,
  output logic [31:0] sample_o,
  output logic        valid_o
);
  rx_cfg_t                cfg;
  logic                   stb, fclk_s, dat_s, tick, bit_v, fresh, fend;
  logic [BIT_CNT_W-1:0]   bis;
  logic [SLOT_IDX_W-1:0]  sidx;

  assign cfg = '{samp_code: samp_w_i, slot_code: slot_w_i, dly: frm_dly_i,
                 pol: fclk_pol_i, tdm: tdm_i, cnt_code: slot_cnt_i,
                 sel: slot_sel_i, rise: rise_i};

  pcm_slot_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rise_i,
    .bclk_i, .fclk_i, .dat_i(sdata_i),
    .stb_o(stb), .fclk_o(fclk_s), .dat_o(dat_s)
  );

  pcm_slot_rx_framer u_framer (
    .clk_i, .rst_ni, .cfg_i(cfg),
    .stb_i(stb), .fclk_i(fclk_s), .dat_i(dat_s),
    .tick_o(tick), .bit_o(bit_v), .bis_o(bis), .sidx_o(sidx),
    .fresh_o(fresh), .end_o(fend)
  );

  pcm_slot_rx_capture u_capture (
    .clk_i, .rst_ni,
    .samp_w_i(width_of(samp_w_i)), .slot_w_i(width_of(slot_w_i)),
    .sel_i(slot_sel_i), .n_slots_i(slots_of(tdm_i, slot_cnt_i)),
    .tick_i(tick), .bit_i(bit_v), .bis_i(bis), .sidx_i(sidx),
    .fresh_i(fresh), .end_i(fend),
    .sample_o, .valid_o
  );
endmodule

// File: tb/pcm_slot_rx_test.sv
module pcm_slot_rx_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_i = 1'b0, fclk_i = 1'b0, sdata_i = 1'b0;
  logic [1:0]  samp_w_i = '0, slot_w_i = '0, frm_dly_i = '0, slot_cnt_i = '0;
  logic        fclk_pol_i = 1'b1, tdm_i = 1'b0, rise_i = 1'b1;
  logic [3:0]  slot_sel_i = '0;
  logic [31:0] sample_o;
  logic        valid_o;

  always #5 clk_i = ~clk_i;

  pcm_slot_rx uut (.*);

  int n_chk = 0, n_fail = 0;
  int cur_g = -1;
  int mon_n = 0;
  logic [31:0] mon_v [16];
  int mon_g [16];
  int e_n;
  int e_fr [8];
  int e_sl [8];
  int sw, smp, eff, nsl, fl, dly;

  always @(negedge clk_i) begin
    if (valid_o) begin
      if (mon_n < 16) begin
        mon_v[mon_n] = sample_o;
        mon_g[mon_n] = cur_g;
      end
      mon_n++;
    end
  end

  function automatic int wcode(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 24 : 32;
  endfunction

  function automatic logic [31:0] word(input int f, input int s);
    return 32'hA5C3_1E97 ^ (32'h9E37_79B9 * 32'(f * 8 + s + 1));
  endfunction

  function automatic logic [31:0] sext(input logic [31:0] w, input int n);
    logic signed [31:0] t;
    t = signed'(w << (32 - n));
    return 32'(t >>> (32 - n));
  endfunction

  function automatic logic tx_fclk(input int g);
    int pos;
    pos = g % fl;
    if (tdm_i) return (pos == 0) ? fclk_pol_i : ~fclk_pol_i;
    return (pos < fl / 2) ? fclk_pol_i : ~fclk_pol_i;
  endfunction

  function automatic logic tx_dat(input int g);
    int k, ff, kp, s, b;
    logic [31:0] w;
    k = g - dly;
    if (k < 0) return 1'b0;
    ff = k / fl; kp = k % fl; s = kp / sw; b = kp % sw;
    if (b >= eff) return 1'b1;
    w = word(ff, s);
    return w[eff - 1 - b];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] sa, input logic [1:0] sl, input logic [1:0] d,
                         input logic p, input logic t, input logic [1:0] c,
                         input logic [3:0] se, input logic r);
    @(posedge clk_i); #1;
    samp_w_i = sa; slot_w_i = sl; frm_dly_i = d; fclk_pol_i = p;
    tdm_i = t; slot_cnt_i = c; slot_sel_i = se; rise_i = r;
    bclk_i = ~r;
    sw  = wcode(sl);
    smp = wcode(sa);
    eff = (smp > sw) ? sw : smp;
    nsl = t ? ((c == 2'b00) ? 2 : (c == 2'b01) ? 4 : 8) : 2;
    fl  = sw * nsl;
    dly = int'(d);
    repeat (4) @(posedge clk_i);
  endtask

  task automatic bit_period(input logic f, input logic d);
    @(posedge clk_i); #1;
    bclk_i = ~rise_i; fclk_i = f; sdata_i = d;
    repeat (4) @(posedge clk_i); #1;
    bclk_i = rise_i;
    repeat (3) @(posedge clk_i);
  endtask

  task automatic stream(input int nf, input int extra, input int abort_pos, input logic [3:0] new_sel);
    int total;
    total = nf * fl + dly + 1 + extra;
    mon_n = 0;
    cur_g = -1;
    bit_period(~fclk_pol_i, 1'b0);
    for (int g = 0; g < total; g++) begin
      cur_g = g;
      if (g == abort_pos) slot_sel_i = new_sel;
      bit_period(tx_fclk(g), tx_dat(g));
    end
    cur_g = 1 << 20;
    repeat (16) @(posedge clk_i);
  endtask

  task automatic verify(input string req);
    logic [31:0] exp;
    int last;
    chk(mon_n == e_n, {req, " pulse count"}, 32'(mon_n), 32'(e_n));
    for (int i = 0; i < e_n && i < mon_n; i++) begin
      exp  = sext(word(e_fr[i], e_sl[i]), eff);
      last = (e_fr[i] + 1) * fl + dly - 1;
      chk(mon_v[i] == exp, {req, " sample"}, mon_v[i], exp);
      chk(mon_g[i] >= last && mon_g[i] <= last + 2, {req, " frame-end bit period"},
          32'(mon_g[i]), 32'(last));
    end
    if (e_n > 0) begin
      exp = sext(word(e_fr[e_n-1], e_sl[e_n-1]), eff);
      @(negedge clk_i);
      chk(sample_o == exp, {req, " R9 hold"}, sample_o, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R12 valid in reset", 32'(valid_o), 32'd0);
    chk(sample_o == 32'd0, "R12 sample in reset", sample_o, 32'd0);
  endtask

  // left-justified, 24-bit in 32-bit slots, slot count code ignored
  task automatic t_lj;
    set_cfg(2'b01, 2'b10, 2'd0, 1'b1, 1'b0, 2'b10, 4'd1, 1'b1);
    stream(3, 0, -1, 4'd0);
    e_n = 3;
    for (int f = 0; f < 3; f++) begin e_fr[f] = f; e_sl[f] = 1; end
    verify("R1 R2 R5 R9 left-justified");
  endtask

  // I2S, delay 1, 16-bit in 32-bit slots, falling edge
  task automatic t_i2s;
    set_cfg(2'b00, 2'b10, 2'd1, 1'b0, 1'b0, 2'b00, 4'd0, 1'b0);
    stream(3, 0, -1, 4'd0);
    e_n = 3;
    for (int f = 0; f < 3; f++) begin e_fr[f] = f; e_sl[f] = 0; end
    verify("R4 R5 R8 i2s");
  endtask

  task automatic t_tdm8;
    set_cfg(2'b00, 2'b00, 2'd0, 1'b1, 1'b1, 2'b10, 4'd5, 1'b1);
    stream(2, 0, -1, 4'd0);
    e_n = 2;
    for (int f = 0; f < 2; f++) begin e_fr[f] = f; e_sl[f] = 5; end
    verify("R6 R7 tdm8");
  endtask

  // 4 slots of 24, delay 2, active-low pulse, last slot selected
  task automatic t_tdm4;
    set_cfg(2'b01, 2'b01, 2'd2, 1'b0, 1'b1, 2'b01, 4'd3, 1'b1);
    stream(2, 0, -1, 4'd0);
    e_n = 2;
    for (int f = 0; f < 2; f++) begin e_fr[f] = f; e_sl[f] = 3; end
    verify("R2 R4 R6 tdm4");
  endtask

  task automatic t_illegal;
    set_cfg(2'b10, 2'b00, 2'd0, 1'b1, 1'b0, 2'b00, 4'd1, 1'b1);
    stream(3, 0, -1, 4'd0);
    e_n = 3;
    for (int f = 0; f < 3; f++) begin e_fr[f] = f; e_sl[f] = 1; end
    verify("R3 clamp");
  endtask

  task automatic t_oob;
    set_cfg(2'b00, 2'b10, 2'd0, 1'b1, 1'b1, 2'b00, 4'd2, 1'b1);
    stream(2, 0, -1, 4'd0);
    e_n = 0;
    verify("R7 out-of-range slot");
  endtask

  task automatic t_short;
    set_cfg(2'b00, 2'b10, 2'd0, 1'b1, 1'b1, 2'b01, 4'd0, 1'b1);
    stream(0, 70, -1, 4'd0);
    e_n = 0;
    verify("R10 truncated frame");
    stream(2, 0, -1, 4'd0);
    e_n = 2;
    for (int f = 0; f < 2; f++) begin e_fr[f] = f; e_sl[f] = 0; end
    verify("R10 after truncation");
  endtask

  task automatic t_resync;
    set_cfg(2'b00, 2'b00, 2'd0, 1'b1, 1'b0, 2'b00, 4'd0, 1'b1);
    stream(3, 0, 40, 4'd1);
    e_n = 2;
    e_fr[0] = 0; e_sl[0] = 0;
    e_fr[1] = 2; e_sl[1] = 1;
    verify("R11 config change");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    #1 rst_ni = 1'b1;
    t_lj();
    t_i2s();
    t_tdm8();
    t_tdm4();
    t_illegal();
    t_oob();
    t_short();
    t_resync();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule